// File: doc/BRIEF.md
# Ethernet Transmit Frame Check Sequence Appender

This block sits in a transmit datapath between the frame source and the line side. It takes a byte stream with start-of-frame, end-of-frame and buffer-boundary markers, runs an IEEE 802.3 CRC-32 over every data byte, and decides separately for each frame whether to append the four check bytes after the last data byte. While it appends, it holds the source off with a ready signal. Every byte, data or check, leaves one cycle after it is accepted or generated.

Three controls feed the decision. A global suppress bit disables the check sequence. An auto-pad enable forces the check sequence on. A per-buffer add flag turns it on for one frame. The per-buffer flag counts only under certain descriptor-style codes. The whole decision is taken from the start-of-frame beat and held until that frame ends. When a later buffer of the same frame carries a different add flag, the block keeps the decision from the first buffer and reports the disagreement on the frame's final output byte.

Top module: `eth_fcs_tx`

## Requirements
- R1: After reset `out_valid`, `out_sof`, `out_eof`, `out_fcs` and `out_flag_bad` are 0 and `in_ready` is 1.
- R2: When `cfg_fcs_off` is 0 at the start-of-frame beat, four check bytes follow the frame's last data byte.
- R3: When `cfg_autopad` is 1 at the start-of-frame beat, four check bytes are appended, whatever the values of `cfg_fcs_off`, `cfg_desc_style` and `in_add_fcs`.
- R4: When `cfg_fcs_off` is 1 and `cfg_autopad` is 0, check bytes are appended exactly when `cfg_desc_style` is 0, 2 or 3 and `in_add_fcs` is 1 on the start-of-frame beat.
- R5: For any other `cfg_desc_style` value, `in_add_fcs` has no effect. With `cfg_fcs_off`=1 and `cfg_autopad`=0, no check bytes are appended.
- R6: The check value is the complement of the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones) over all data bytes of the frame. It is sent low-order byte first, so that the x^31 coefficient leads on a line that serialises each byte LSB first. For the ASCII data "123456789" the bytes are 0x26, 0x39, 0xF4, 0xCB.
- R7: The decision uses only the control values present on the start-of-frame beat. Changes to `cfg_fcs_off`, `cfg_autopad` or `cfg_desc_style` later in the frame do not change it.
- R8: When the style is 0, 2 or 3 and a beat with `in_buf_first`=1 inside a frame (not the start beat) carries an `in_add_fcs` that differs from the start beat's, the start beat's value still decides. `out_flag_bad` is 1 on that frame's final output byte and 0 on every other output byte.
- R9: Each accepted input byte appears on `out_data` with `out_valid`=1 one cycle later, in order. `in_ready` is 0 from the cycle after an accepted end-of-frame beat that leads to appending, for four cycles.
- R10: `out_sof` marks the first data byte. `out_fcs` is 1 on exactly the four check bytes. `out_eof` is 1 only on the last output byte of the frame: the last check byte when appending, otherwise the last data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fcs_off | input | 1 | Global suppress of the check sequence |
| cfg_autopad | input | 1 | Auto-pad enabled; forces the check sequence |
| cfg_desc_style | input | 8 | Descriptor style code |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input data byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_buf_first | input | 1 | First byte of a buffer |
| in_add_fcs | input | 1 | Buffer's add flag, read when in_buf_first is 1 |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| out_fcs | output | 1 | Output byte is a check byte |
| out_flag_bad | output | 1 | Add flag disagreed across buffers (on final byte) |

## Verification
A CRC register that is wrong, or was not preset at the frame start, corrupts all four check bytes of that frame. The error appears within four cycles of the end-of-frame beat. A wrong or unlatched decision shows as a frame that is four bytes too long or too short, and `in_ready` then drops or fails to drop on the cycle after the end beat. A lost or stuck disagreement flag shows on the very next final output byte.

// File: rtl/eth_fcs_pkg.sv
package eth_fcs_pkg;
  localparam int BYTE_W    = 8;
  localparam int CRC_W     = 32;
  localparam int FCS_BYTES = CRC_W / BYTE_W;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_PRESET    = 32'hFFFFFFFF;

  typedef enum logic [0:0] {ST_PASS, ST_APPEND} fcs_state_e;

  // one byte through the reflected CRC-32, LSB of the byte first
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // descriptor style codes under which the per-buffer flag is honoured
  function automatic logic style_honours_flag(input logic [7:0] s);
    return (s == 8'd0) || (s == 8'd2) || (s == 8'd3);
  endfunction
endpackage

// File: rtl/eth_fcs_crc.sv
module eth_fcs_crc
  import eth_fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_next
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;

  assign crc_base = first ? CRC_PRESET : crc_q;
  assign crc_next = crc_byte(crc_base, data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= CRC_PRESET;
    else if (take) crc_q <= crc_next;
  end
endmodule

// File: rtl/eth_fcs_decide.sv
module eth_fcs_decide
  import eth_fcs_pkg::*;
#(
  parameter int STYLE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               sof,
  input  logic               buf_first,
  input  logic               add_fcs,
  input  logic               fcs_off,
  input  logic               autopad,
  input  logic [STYLE_W-1:0] style,
  output logic               append_now,
  output logic               bad_now
);
  logic append_q, sop_flag_q, style_ok_q, bad_q;
  logic style_ok_in, append_in, diff_here;

  assign style_ok_in = style_honours_flag(8'(style));
  assign append_in   = autopad | ~fcs_off | (style_ok_in & add_fcs);
  assign append_now  = sof ? append_in : append_q;
  assign diff_here   = ~sof & buf_first & style_ok_q & (add_fcs != sop_flag_q);
  assign bad_now     = sof ? 1'b0 : (bad_q | diff_here);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      append_q   <= 1'b0;
      sop_flag_q <= 1'b0;
      style_ok_q <= 1'b0;
      bad_q      <= 1'b0;
    end else if (take) begin
      if (sof) begin
        append_q   <= append_in;
        sop_flag_q <= add_fcs;
        style_ok_q <= style_ok_in;
        bad_q      <= 1'b0;
      end else begin
        bad_q <= bad_now;
      end
    end
  end
endmodule

// File: rtl/eth_fcs_tx.sv
module eth_fcs_tx
  import eth_fcs_pkg::*;
#(
  parameter int STYLE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_fcs_off,
  input  logic               cfg_autopad,
  input  logic [STYLE_W-1:0] cfg_desc_style,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic               in_buf_first,
  input  logic               in_add_fcs,
  output logic               out_valid,
  output logic [7:0]         out_data,
  output logic               out_sof,
  output logic               out_eof,
  output logic               out_fcs,
  output logic               out_flag_bad
);
  localparam int CNT_W = $clog2(FCS_BYTES);

  fcs_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CRC_W-1:0]  fcs_q;
  logic              bad_hold_q;
  logic              take, append_now, bad_now, start_append;
  logic [CRC_W-1:0]  crc_next;

  assign in_ready     = (st_q == ST_PASS);
  assign take         = in_valid & in_ready;
  assign start_append = take & in_eof & append_now;

  eth_fcs_crc u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(in_sof),
    .data(in_data), .crc_next(crc_next)
  );

  eth_fcs_decide #(.STYLE_W(STYLE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof),
    .buf_first(in_buf_first), .add_fcs(in_add_fcs),
    .fcs_off(cfg_fcs_off), .autopad(cfg_autopad), .style(cfg_desc_style),
    .append_now(append_now), .bad_now(bad_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_PASS;
      cnt_q      <= '0;
      fcs_q      <= '0;
      bad_hold_q <= 1'b0;
    end else if (st_q == ST_PASS) begin
      if (start_append) begin
        st_q       <= ST_APPEND;
        cnt_q      <= '0;
        fcs_q      <= ~crc_next;
        bad_hold_q <= bad_now;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(FCS_BYTES - 1)) st_q <= ST_PASS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_sof      <= 1'b0;
      out_eof      <= 1'b0;
      out_fcs      <= 1'b0;
      out_flag_bad <= 1'b0;
    end else if (st_q == ST_APPEND) begin
      out_valid    <= 1'b1;
      out_data     <= fcs_q[BYTE_W*cnt_q +: BYTE_W];
      out_sof      <= 1'b0;
      out_eof      <= (cnt_q == CNT_W'(FCS_BYTES - 1));
      out_fcs      <= 1'b1;
      out_flag_bad <= (cnt_q == CNT_W'(FCS_BYTES - 1)) & bad_hold_q;
    end else begin
      out_valid    <= take;
      out_data     <= in_data;
      out_sof      <= take & in_sof;
      out_eof      <= take & in_eof & ~append_now;
      out_fcs      <= 1'b0;
      out_flag_bad <= take & in_eof & ~append_now & bad_now;
    end
  end
endmodule

// File: rtl/eth_fcs_tx_chk.sv
module eth_fcs_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_eof,
  input logic out_valid,
  input logic out_sof,
  input logic out_eof,
  input logic out_fcs,
  input logic out_flag_bad
);
  // R9
  accepted_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R9
  hold_during_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fcs && !out_eof) |-> !in_ready);
  // R9
  ready_drop_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && in_eof));
  // R10
  sof_not_fcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> !out_fcs);
  // R10
  fcs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fcs && out_eof) |-> $past(out_fcs));
  // R8
  bad_on_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_flag_bad |-> (out_eof && out_valid));
endmodule

bind eth_fcs_tx eth_fcs_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_eof(in_eof), .out_valid(out_valid), .out_sof(out_sof),
  .out_eof(out_eof), .out_fcs(out_fcs), .out_flag_bad(out_flag_bad)
);

// File: tb/eth_fcs_tx_tb.sv
module eth_fcs_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fcs_off = 1'b0, cfg_autopad = 1'b0;
  logic [7:0] cfg_desc_style = 8'd0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_buf_first = 1'b0, in_add_fcs = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic in_ready, out_valid, out_sof, out_eof, out_fcs, out_flag_bad;
  logic [7:0] out_data;

  int total = 0, bad = 0;
  logic [7:0] fr [0:63];
  logic [7:0] cap_d [0:127];
  logic [4:0] cap_f [0:127];
  int ncap = 0;

  always #5 clk = ~clk;

  eth_fcs_tx u_dut (.*);

  always @(negedge clk) begin
    if (out_valid && ncap < 128) begin
      cap_d[ncap] = out_data;
      cap_f[ncap] = {out_sof, out_eof, out_fcs, out_flag_bad, 1'b1};
      ncap++;
    end
  end

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // normal-order CRC over bit-reversed bytes, then reversed back
  function automatic logic [31:0] ref_fcs(input int len);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < len; k++) begin
      logic [7:0] b;
      for (int i = 0; i < 8; i++) b[i] = fr[k][7-i];
      c = c ^ {b, 24'd0};
      for (int i = 0; i < 8; i++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    end
    return ~rev32(c);
  endfunction

  task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input int bsz, input logic f0, input logic mism,
                            input logic flip, input logic off, input logic ap, input logic [7:0] sty,
                            input string tag);
    logic app, exp_bad, ok_d, ok_m;
    logic [31:0] fcs;
    int exp_len;
    app = ap || !off || ((sty == 8'd0 || sty == 8'd2 || sty == 8'd3) && f0);
    exp_bad = mism && (len > bsz) && (sty == 8'd0 || sty == 8'd2 || sty == 8'd3);
    exp_len = len + (app ? 4 : 0);
    fcs = ref_fcs(len);
    ncap = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      if (i == 0) begin
        cfg_fcs_off = off; cfg_autopad = ap; cfg_desc_style = sty;
      end else if (flip && i == 1) begin
        cfg_fcs_off = ~off; cfg_autopad = ~ap; cfg_desc_style = sty ^ 8'd1;
      end
      in_valid = 1'b1; in_data = fr[i];
      in_sof = (i == 0); in_eof = (i == len - 1);
      in_buf_first = (i % bsz == 0);
      in_add_fcs = (mism && i == bsz) ? ~f0 : f0;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_buf_first = 1'b0;
    repeat (8) @(negedge clk);
    chk({tag, " length"}, ncap == exp_len, ncap, exp_len);
    ok_d = (ncap == exp_len); ok_m = (ncap == exp_len);
    if (ncap == exp_len) begin
      for (int i = 0; i < exp_len; i++) begin
        logic [7:0] e;
        logic [4:0] ef;
        e = (i < len) ? fr[i] : fcs[8*(i-len) +: 8];
        ef = {i == 0, i == exp_len - 1, i >= len, (i == exp_len - 1) && exp_bad, 1'b1};
        if (cap_d[i] != e) ok_d = 1'b0;
        if (cap_f[i] != ef) ok_m = 1'b0;
      end
    end
    chk({tag, " R6 bytes"}, ok_d, {24'd0, cap_d[exp_len-1]}, app ? {24'd0, fcs[31:24]} : 32'd0);
    chk({tag, " R10 R8 markers"}, ok_m, {27'd0, cap_f[exp_len-1]}, {30'd0, exp_bad, 1'b1});
  endtask

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < len; i++) fr[i] = 8'((i * 37 + seed * 11 + 5) & 255);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] styles [0:5];
    int n;
    styles[0] = 8'd0; styles[1] = 8'd1; styles[2] = 8'd2;
    styles[3] = 8'd3; styles[4] = 8'd4; styles[5] = 8'd255;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {out_valid, out_sof, out_eof, out_fcs, out_flag_bad} == 5'd0,
        {out_valid, out_sof, out_eof, out_fcs, out_flag_bad}, 0);
    chk("R1 reset ready", in_ready == 1'b1, in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 known vector "123456789"
    for (int i = 0; i < 9; i++) fr[i] = 8'h31 + 8'(i);
    send_frame(9, 64, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, "R6 vector");
    chk("R6 vector byte0", cap_d[9] == 8'h26, cap_d[9], 8'h26);
    chk("R6 vector byte3", cap_d[12] == 8'hCB, cap_d[12], 8'hCB);
    // R2 R3 R4 R5 sweep over controls
    n = 0;
    for (int off = 0; off < 2; off++)
      for (int ap = 0; ap < 2; ap++)
        for (int s = 0; s < 6; s++)
          for (int f = 0; f < 2; f++) begin
            fill(3 + n % 14, n);
            send_frame(3 + n % 14, 4, f[0], 1'b0, 1'b0, off[0], ap[0], styles[s],
                       ap ? "R3" : (!off ? "R2" : (s == 1 || s > 3) ? "R5" : "R4"));
            n++;
          end
    // R9 single-byte frames, back to back
    fill(1, 7);
    send_frame(1, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, "R9 one byte app");
    send_frame(1, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0, "R9 one byte bare");
    // R7 control changes mid-frame
    for (int k = 0; k < 4; k++) begin
      fill(10, 50 + k);
      send_frame(10, 3, k[0], 1'b0, 1'b1, k[1], 1'b0, 8'd2, "R7 mid change");
    end
    // R8 disagreement between buffers
    for (int k = 0; k < 4; k++) begin
      fill(12, 70 + k);
      send_frame(12, 4, k[0], 1'b1, 1'b0, 1'b1, 1'b0, k[1] ? 8'd3 : 8'd1, "R8 mismatch");
    end
    fill(12, 90);
    send_frame(12, 4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0, "R8 clean after");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule